// File: doc/BRIEF.md
# T-Flag Integer ALU

This block is the integer arithmetic stage of a small processor datapath. It takes an operation code, two 32-bit operands (the destination operand `rn` and the source operand `rm`) and the current value of a one-bit condition flag, and one clock later it returns a 32-bit result and the next value of that flag. The one flag bit does several jobs. It carries into additions. It is the borrow for subtractions and negations. It reports signed overflow. It signals a zero count for the loop-decrement operation.

The add-with-carry and subtract-with-borrow operations treat the flag as the outgoing carry of the whole two-stage operation. The flag is therefore raised if either the operand stage or the flag stage wraps. All arithmetic shares one adder, and the operation code sets how that adder's operands are formed. The overflow detector is built as one of two equivalent circuits, chosen by a parameter.

A caller drives `in_valid` together with its operands. The registered result and flag appear with `out_valid` on the next cycle. When `in_valid` is low, the output registers keep their values.

Top module: `tflag_alu`

## Requirements
- R1: Operation code 0 (add with carry) returns rn + rm + T, wrapped to the data width. The new T is 1 when that sum exceeds the largest unsigned value, which covers a wrap in either the rn + rm stage or the + T stage.
- R2: Operation code 1 (subtract with borrow) returns rn − rm − T, wrapped. The new T is 1 when rm + T is greater than rn as unsigned numbers, which means either stage borrowed.
- R3: Operation code 2 (negate with borrow) returns 0 − rm − T, wrapped. The new T is 1 when rm or T is nonzero.
- R4: Operation code 3 (add with overflow check) returns the wrapped sum rn + rm. The new T is 1 exactly when the two's-complement sum lies outside −2^(W−1) .. 2^(W−1)−1.
- R5: Operation code 4 (subtract with overflow check) returns the wrapped difference rn − rm. The new T is 1 exactly when the signed difference lies outside the same range.
- R6: Operation code 5 (decrement and test) returns rn − 1. The new T is 1 only when that result is zero.
- R7: Operation code 6 (negate) returns 0 − rm, and operation code 7 (invert) returns the bitwise complement of rm. Both copy the incoming T unchanged to the outgoing T.
- R8: Operation codes 8 to 15 are unrecognised. They return a result of zero and copy the incoming T unchanged.
- R9: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result and flag for that input appear in the same cycle.
- R10: In a cycle with `in_valid` low, the result and flag outputs keep their previous values, whatever the operand and operation inputs are.
- R11: While reset (`rst_n` low) is active, and after it is released, `out_valid`, `result` and `t_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and operation code are valid this cycle |
| op | input | 4 | Operation code (see R1 to R8) |
| rn | input | DATA_W | Destination-side operand |
| rm | input | DATA_W | Source-side operand |
| t_in | input | 1 | Current flag value |
| out_valid | output | 1 | Result and flag are valid |
| result | output | DATA_W | Registered result |
| t_out | output | 1 | Registered next flag value |

## Verification
The bound checker watches every cycle of real traffic. It checks the valid-to-valid latency, the holding of outputs on idle cycles, the carry of add-with-carry, the zero rule of decrement-and-test, signed overflow for addition, and the flag pass-through of negate, invert and unrecognised codes. The borrow flags of the subtract and negate forms, and the overflow of subtraction, are shown only by the bench. The bench sweeps every destination operand against a set of source operands that includes zero, one and the signed limits, with both flag values, on a narrow instance. It also checks that both overflow circuits give identical results.

// File: rtl/tflag_alu_pkg.sv
package tflag_alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OPC_ADD_CARRY  = 4'd0,
      OPC_SUB_BORROW = 4'd1,
      OPC_NEG_BORROW = 4'd2,
      OPC_ADD_OVF    = 4'd3,
      OPC_SUB_OVF    = 4'd4,
      OPC_DEC_TEST   = 4'd5,
      OPC_NEGATE     = 4'd6,
      OPC_INVERT     = 4'd7
   } alu_opc_e;

   // where the result word comes from
   typedef enum logic [1:0] {
      RSRC_SUM  = 2'd0,
      RSRC_INV  = 2'd1,
      RSRC_ZERO = 2'd2
   } res_src_e;

   // where the next flag comes from
   typedef enum logic [2:0] {
      TSRC_KEEP   = 3'd0,
      TSRC_CARRY  = 3'd1,
      TSRC_BORROW = 3'd2,
      TSRC_OVF    = 3'd3,
      TSRC_ZERO   = 3'd4
   } t_src_e;

   typedef struct packed {
      res_src_e res_src;
      t_src_e   t_src;
   } alu_ctl_t;

endpackage

// File: rtl/tfa_op_steer.sv
// Forms the shared adder's operands and the result/flag selectors
// from the operation code. Subtractions become a + ~b + carry-in.
module tfa_op_steer
   import tflag_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] rn,
   input  logic [DATA_W-1:0] rm,
   input  logic              t_in,
   output logic [DATA_W-1:0] add_a,
   output logic [DATA_W-1:0] add_b,
   output logic              add_cin,
   output alu_ctl_t          ctl
);

   localparam logic [DATA_W-1:0] ALL_ZERO = '0;
   localparam logic [DATA_W-1:0] ALL_ONE  = '1;

   always_comb begin
      add_a       = rn;
      add_b       = rm;
      add_cin     = 1'b0;
      ctl.res_src = RSRC_SUM;
      ctl.t_src   = TSRC_KEEP;
      case (alu_opc_e'(op))
         OPC_ADD_CARRY: begin
            add_cin   = t_in;
            ctl.t_src = TSRC_CARRY;
         end
         OPC_SUB_BORROW: begin
            add_b     = ~rm;
            add_cin   = ~t_in;
            ctl.t_src = TSRC_BORROW;
         end
         OPC_NEG_BORROW: begin
            add_a     = ALL_ZERO;
            add_b     = ~rm;
            add_cin   = ~t_in;
            ctl.t_src = TSRC_BORROW;
         end
         OPC_ADD_OVF: begin
            ctl.t_src = TSRC_OVF;
         end
         OPC_SUB_OVF: begin
            add_b     = ~rm;
            add_cin   = 1'b1;
            ctl.t_src = TSRC_OVF;
         end
         OPC_DEC_TEST: begin
            add_b     = ALL_ONE;
            ctl.t_src = TSRC_ZERO;
         end
         OPC_NEGATE: begin
            add_a   = ALL_ZERO;
            add_b   = ~rm;
            add_cin = 1'b1;
         end
         OPC_INVERT: begin
            ctl.res_src = RSRC_INV;
         end
         default: begin
            ctl.res_src = RSRC_ZERO;
         end
      endcase
   end

endmodule

// File: rtl/tfa_adder.sv
// One carry-propagate adder shared by every arithmetic operation.
module tfa_adder #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);

   localparam int EXT_W = DATA_W + 1;

   logic [EXT_W-1:0] wide;

   always_comb begin
      wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
      sum  = wide[DATA_W-1:0];
      cout = wide[DATA_W];
   end

endmodule

// File: rtl/tfa_flag_gen.sv
// Picks the result word and the next flag. OVF_STYLE selects the
// overflow circuit: 0 compares operand and sum signs, 1 compares the
// carries into and out of the sign bit.
module tfa_flag_gen
   import tflag_alu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int OVF_STYLE = 0
) (
   input  alu_ctl_t          ctl,
   input  logic [DATA_W-1:0] add_a,
   input  logic [DATA_W-1:0] add_b,
   input  logic [DATA_W-1:0] sum,
   input  logic              cout,
   input  logic [DATA_W-1:0] rm,
   input  logic              t_in,
   output logic [DATA_W-1:0] res_next,
   output logic              t_next
);

   localparam int MSB = DATA_W - 1;

   logic ovf;

   generate
      if (OVF_STYLE == 0) begin : g_sign_cmp
         assign ovf = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);
      end else begin : g_carry_cmp
         logic carry_into_msb;
         assign carry_into_msb = sum[MSB] ^ add_a[MSB] ^ add_b[MSB];
         assign ovf            = carry_into_msb ^ cout;
      end
   endgenerate

   always_comb begin
      case (ctl.res_src)
         RSRC_SUM: res_next = sum;
         RSRC_INV: res_next = ~rm;
         default:  res_next = '0;
      endcase
      case (ctl.t_src)
         TSRC_CARRY:  t_next = cout;
         TSRC_BORROW: t_next = ~cout;
         TSRC_OVF:    t_next = ovf;
         TSRC_ZERO:   t_next = (sum == '0);
         default:     t_next = t_in;
      endcase
   end

endmodule

// File: rtl/tfa_out_reg.sv
// Output stage: one cycle of latency, outputs held on idle cycles.
module tfa_out_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] res_next,
   input  logic              t_next,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              t_out
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         t_out     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= res_next;
            t_out  <= t_next;
         end
      end
   end

endmodule

// File: rtl/tflag_alu.sv
module tflag_alu
   import tflag_alu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int OVF_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] rn,
   input  logic [DATA_W-1:0] rm,
   input  logic              t_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              t_out
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("tflag_alu: DATA_W must be at least 2");
      end
      if (OVF_STYLE != 0 && OVF_STYLE != 1) begin : g_bad_style
         $error("tflag_alu: OVF_STYLE must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] add_a;
   logic [DATA_W-1:0] add_b;
   logic              add_cin;
   alu_ctl_t          ctl;
   logic [DATA_W-1:0] sum;
   logic              cout;
   logic [DATA_W-1:0] res_next;
   logic              t_next;

   tfa_op_steer #(.DATA_W(DATA_W)) u_steer (
      .op      (op),
      .rn      (rn),
      .rm      (rm),
      .t_in    (t_in),
      .add_a   (add_a),
      .add_b   (add_b),
      .add_cin (add_cin),
      .ctl     (ctl)
   );

   tfa_adder #(.DATA_W(DATA_W)) u_adder (
      .a    (add_a),
      .b    (add_b),
      .cin  (add_cin),
      .sum  (sum),
      .cout (cout)
   );

   tfa_flag_gen #(.DATA_W(DATA_W), .OVF_STYLE(OVF_STYLE)) u_flags (
      .ctl      (ctl),
      .add_a    (add_a),
      .add_b    (add_b),
      .sum      (sum),
      .cout     (cout),
      .rm       (rm),
      .t_in     (t_in),
      .res_next (res_next),
      .t_next   (t_next)
   );

   tfa_out_reg #(.DATA_W(DATA_W)) u_oreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .res_next  (res_next),
      .t_next    (t_next),
      .out_valid (out_valid),
      .result    (result),
      .t_out     (t_out)
   );

endmodule

// File: rtl/tflag_alu_checker.sv
module tflag_alu_checker
   import tflag_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [OP_W-1:0]   op,
   input logic [DATA_W-1:0] rn,
   input logic [DATA_W-1:0] rm,
   input logic              t_in,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic              t_out
);

   localparam int MSB = DATA_W - 1;

   logic is_addc, is_addv, is_dect, is_keep, is_unknown;
   assign is_addc    = in_valid && (op == OPC_ADD_CARRY);
   assign is_addv    = in_valid && (op == OPC_ADD_OVF);
   assign is_dect    = in_valid && (op == OPC_DEC_TEST);
   assign is_keep    = in_valid && (op == OPC_NEGATE || op == OPC_INVERT);
   assign is_unknown = in_valid && (op[OP_W-1] == 1'b1);

   assert_addc_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      is_addc |=> {t_out, result} ==
         ({1'b0, $past(rn)} + {1'b0, $past(rm)} + {{DATA_W{1'b0}}, $past(t_in)}));

   assert_addv_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      is_addv |=> t_out == (($past(rn[MSB]) == $past(rm[MSB])) &&
                            (result[MSB] != $past(rn[MSB]))));

   assert_dect_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      is_dect |=> (t_out == (result == '0)) && (result == $past(rn) - 1'b1));

   assert_keep_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_keep |=> t_out == $past(t_in));

   assert_unknown_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
      is_unknown |=> (result == '0) && (t_out == $past(t_in)));

   assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_valid_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result) && $stable(t_out));

   always_comb begin
      if (!rst_n) begin
         assert_reset_clear_R11: assert (!out_valid && result == '0 && !t_out);
      end
   end

endmodule

bind tflag_alu tflag_alu_checker #(.DATA_W(DATA_W)) u_tflag_alu_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .rn        (rn),
   .rm        (rm),
   .t_in      (t_in),
   .out_valid (out_valid),
   .result    (result),
   .t_out     (t_out)
);

// File: tb/test_tflag_alu.sv
`timescale 1ns/1ps
module test_tflag_alu;

   localparam int W = 8;
   localparam longint SMAX = (longint'(1) <<< (W-1)) - 1;
   localparam longint SMIN = -(longint'(1) <<< (W-1));
   localparam longint UMOD = longint'(1) <<< W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [3:0]   op = '0;
   logic [W-1:0] rn = '0;
   logic [W-1:0] rm = '0;
   logic         t_in = 1'b0;
   logic         out_valid, out_valid_alt;
   logic [W-1:0] result, result_alt;
   logic         t_out, t_out_alt;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   tflag_alu #(.DATA_W(W), .OVF_STYLE(0)) i_tflag_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .rn(rn),
      .rm(rm), .t_in(t_in), .out_valid(out_valid), .result(result), .t_out(t_out));

   tflag_alu #(.DATA_W(W), .OVF_STYLE(1)) i_tflag_alu_alt (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .rn(rn),
      .rm(rm), .t_in(t_in), .out_valid(out_valid_alt), .result(result_alt),
      .t_out(t_out_alt));

   function automatic longint sx(input logic [W-1:0] v);
      return v[W-1] ? longint'(v) - UMOD : longint'(v);
   endfunction

   // expected {t, result}, computed from the requirements
   function automatic logic [W:0] model(input logic [3:0] o, input logic [W-1:0] a,
                                        input logic [W-1:0] b, input logic t);
      longint u, s;
      logic [W-1:0] r;
      logic tn;
      u = 0; s = 0; r = '0; tn = t;
      case (o)
         4'd0: begin u = longint'(a) + longint'(b) + longint'(t);
                     r = W'(u); tn = (u >= UMOD); end                       // R1
         4'd1: begin u = longint'(a) - longint'(b) - longint'(t);
                     r = W'(u); tn = (u < 0); end                           // R2
         4'd2: begin u = 0 - longint'(b) - longint'(t);
                     r = W'(u); tn = (u < 0); end                           // R3
         4'd3: begin s = sx(a) + sx(b); r = W'(s); tn = (s > SMAX) || (s < SMIN); end // R4
         4'd4: begin s = sx(a) - sx(b); r = W'(s); tn = (s > SMAX) || (s < SMIN); end // R5
         4'd5: begin r = a - 1'b1; tn = (r == '0); end                      // R6
         4'd6: begin r = -b; tn = t; end                                    // R7
         4'd7: begin r = ~b; tn = t; end                                    // R7
         default: begin r = '0; tn = t; end                                 // R8
      endcase
      return {tn, r};
   endfunction

   function automatic logic [W-1:0] rm_pick(input int j);
      case (j)
         0: return '0;
         1: return W'(1);
         2: return W'(2);
         3: return W'(SMAX);
         4: return W'(SMAX + 1);
         5: return W'(SMAX + 2);
         6: return '1;
         7: return W'(UMOD - 2);
         default: return W'(j * 37 + 11);
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'd0: return "R1"; 4'd1: return "R2"; 4'd2: return "R3";
         4'd3: return "R4"; 4'd4: return "R5"; 4'd5: return "R6";
         4'd6, 4'd7: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic apply(input logic [3:0] o, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic t);
      logic [W:0] e;
      in_valid = 1'b1; op = o; rn = a; rm = b; t_in = t;
      e = model(o, a, b, t);
      @(negedge clk);
      check(req_of(o), "t,result", longint'({t_out, result}), longint'(e));
      check(req_of(o), "alt t,result", longint'({t_out_alt, result_alt}), longint'(e));
      check("R9", "out_valid", longint'(out_valid), 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [W:0] held;
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11", "out_valid in reset", longint'(out_valid), 0);
      check("R11", "result in reset", longint'(result), 0);
      check("R11", "t_out in reset", longint'(t_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", "out_valid after reset", longint'(out_valid), 0);
      check("R11", "t,result after reset", longint'({t_out, result}), 0);

      // R1..R7 sweeps: every rn, chosen rm values, both flag values
      for (int o = 0; o < 8; o++)
         for (int a = 0; a < (1 << W); a++)
            for (int j = 0; j < 16; j++)
               for (int t = 0; t < 2; t++)
                  apply(4'(o), W'(a), rm_pick(j), 1'(t));

      // R8: unrecognised codes
      for (int o = 8; o < 16; o++)
         for (int j = 0; j < 16; j++)
            for (int t = 0; t < 2; t++)
               apply(4'(o), W'(j * 13 + 5), rm_pick(j), 1'(t));

      // R10 and R9: idle cycles keep outputs and drop out_valid
      apply(4'd0, '1, W'(1), 1'b1);
      held = {t_out, result};
      in_valid = 1'b0; op = 4'd7; rn = W'(3); rm = W'(5); t_in = 1'b0;
      @(negedge clk);
      check("R9", "out_valid after idle", longint'(out_valid), 0);
      check("R10", "held t,result", longint'({t_out, result}), longint'(held));
      op = 4'd2; rm = '0; t_in = 1'b1;
      @(negedge clk);
      check("R10", "held t,result second idle", longint'({t_out, result}), longint'(held));
      check("R10", "alt held", longint'({t_out_alt, result_alt}), longint'(held));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule